// File: doc/BRIEF.md
# Nested Interrupt Acknowledge and Completion Tracker

This block sits beside a per-target priority selector in an interrupt controller and keeps the state of the interrupts that one processor is currently servicing. When the processor takes an interrupt, it issues an acknowledge request. The tracker compares the highest-pending candidate with the priority of the interrupt that is now running. If the candidate wins, the tracker returns its ID, clears its pending state and makes it the running interrupt. If the candidate does not win, the tracker returns the spurious ID 1023 and changes nothing.

Preempted interrupts form a chain. A link table indexed by interrupt ID records, for each interrupt taken, which interrupt it preempted. A completion write normally retires the running interrupt and pops the chain. Completions may also arrive out of order. In that case the tracker walks the chain one link per cycle, unlinks the completed interrupt from the middle of the chain and leaves the running interrupt as it was. On every valid completion, a level-sensitive source that is still asserted, enabled and routed to this processor is made pending again.

The priority encoding is numeric: a lower value means a more urgent interrupt. The running priority is one bit wider than a source priority. Its idle value is 2^PRIO_W, which is 0x100 for 8-bit priorities.

Top module: `ackt_tracker`

## Requirements
- R1: An acknowledge returns ID 1023 and leaves the running ID, the running priority, the link table and all pending outputs unchanged in two cases: the candidate ID is 1023 (or not below NUM_SRC), or the candidate priority is not strictly lower than the running priority.
- R2: A successful acknowledge returns the candidate ID. The response (`ack_vld` high for one cycle) appears in the cycle after the request. The candidate becomes the running ID, with the candidate priority as the running priority, and the previous running ID is stored as its link entry.
- R3: A successful acknowledge pulses exactly one pending-clear bit, at the position of the acknowledged ID. The bit goes on `pend_clr_all` when that source's `src_all` bit is 1, and on `pend_clr_self` otherwise.
- R4: A completion whose ID is NUM_SRC or above is ignored, and this includes 1023. It produces no pending-set pulse, no state change and no busy period.
- R5: A completion is ignored while the running ID is 1023.
- R6: A valid completion pulses `pend_set` at the completed ID's position when that source has `src_edge`=0 (level-sensitive), `src_en`=1, `src_level`=1 and `src_tgt`=1. Otherwise `pend_set` stays zero.
- R7: Completing the running ID sets the running ID to its link entry. The running priority becomes that entry's priority from `src_prio`, or 2^PRIO_W when the entry is 1023.
- R8: Completing a non-running ID raises `busy` and walks the chain from the running ID until it finds the completed ID. It then overwrites the referring link entry with the completed ID's own link entry. The running ID and running priority stay unchanged.
- R9: Requests that arrive while `busy` is high are dropped. When an acknowledge and a completion arrive in the same idle cycle, the acknowledge is served and the completion is dropped.
- R10: After reset the running ID is 1023, the running priority is 2^PRIO_W, `busy` and `ack_vld` are low, and every pending output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ack_req | input | 1 | Acknowledge request, one-cycle pulse |
| ack_vld | output | 1 | Acknowledge response valid |
| ack_id | output | 10 | Acknowledged ID, or 1023 |
| cmp_req | input | 1 | Completion write strobe |
| cmp_id | input | 10 | ID being completed |
| hp_id | input | 10 | Highest-pending ID from the selector |
| hp_prio | input | PRIO_W | Priority of hp_id |
| src_prio | input | NUM_SRC*PRIO_W | Per-source priority, source i at bits [i*PRIO_W +: PRIO_W] |
| src_edge | input | NUM_SRC | 1 = edge-triggered, 0 = level-sensitive |
| src_all | input | NUM_SRC | 1 = acknowledge clears pending for all targets |
| src_en | input | NUM_SRC | Source enabled |
| src_level | input | NUM_SRC | Current input level of the source |
| src_tgt | input | NUM_SRC | Source routed to this processor |
| pend_set | output | NUM_SRC | One-cycle pending-set pulses for this target |
| pend_clr_self | output | NUM_SRC | One-cycle pending-clear pulses for this target |
| pend_clr_all | output | NUM_SRC | One-cycle pending-clear pulses for all targets |
| run_id | output | 10 | Running interrupt ID |
| run_prio | output | PRIO_W+1 | Running priority |
| busy | output | 1 | Chain walk in progress |

## Verification
Acknowledges are tried with three kinds of candidate: the spurious ID, a candidate whose priority equals the running priority, and candidates that are strictly more urgent. Together these separate a strict comparison from a non-strict one, and a rejection from a take. The completion sequences cover three cases. An in-order pop separates the running-ID update from the running-priority update. An out-of-order completion followed by pops shows whether the splice rewrote the right link. When the chain ends at idle after an unlink, a missing splice shows up as a wrong running ID. Level versus edge sources, an acknowledge and a completion in the same cycle, and a request during a walk tell apart the re-pend rule, the arbitration rule and the busy gating.

// File: rtl/ackt_pkg.sv
package ackt_pkg;
   localparam int ID_W = 10;
   localparam logic [ID_W-1:0] ACKT_SPUR = 10'h3FF;
   typedef enum logic [0:0] {ACKT_IDLE, ACKT_WALK} ackt_state_e;
endpackage

// File: rtl/ackt_link_mem.sv
module ackt_link_mem import ackt_pkg::*; #(
   parameter int NUM_SRC = 32
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       we,
   input  logic [$clog2(NUM_SRC)-1:0] waddr,
   input  logic [ID_W-1:0]            wdata,
   input  logic [$clog2(NUM_SRC)-1:0] raddr_a,
   output logic [ID_W-1:0]            rdata_a,
   input  logic [$clog2(NUM_SRC)-1:0] raddr_b,
   output logic [ID_W-1:0]            rdata_b
);
   localparam int AW = $clog2(NUM_SRC);

   logic [ID_W-1:0] link_q [NUM_SRC];

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            link_q[i] <= ACKT_SPUR;
         end else if (we && waddr == AW'(i)) begin
            link_q[i] <= wdata;
         end
      end
   end

   assign rdata_a = link_q[raddr_a];
   assign rdata_b = link_q[raddr_b];
endmodule

// File: rtl/ackt_pend_dec.sv
module ackt_pend_dec #(
   parameter int NUM_SRC = 32
) (
   input  logic                       ack_fire,
   input  logic [$clog2(NUM_SRC)-1:0] ack_idx,
   input  logic                       cmp_fire,
   input  logic [$clog2(NUM_SRC)-1:0] cmp_idx,
   input  logic [NUM_SRC-1:0]         src_edge,
   input  logic [NUM_SRC-1:0]         src_all,
   input  logic [NUM_SRC-1:0]         src_en,
   input  logic [NUM_SRC-1:0]         src_level,
   input  logic [NUM_SRC-1:0]         src_tgt,
   output logic [NUM_SRC-1:0]         set_v,
   output logic [NUM_SRC-1:0]         clr_self_v,
   output logic [NUM_SRC-1:0]         clr_all_v
);
   localparam int AW = $clog2(NUM_SRC);

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      logic ack_here;
      logic cmp_here;
      assign ack_here      = ack_fire && (ack_idx == AW'(i));
      assign cmp_here      = cmp_fire && (cmp_idx == AW'(i));
      assign set_v[i]      = cmp_here && !src_edge[i] && src_en[i] && src_level[i] && src_tgt[i];
      assign clr_self_v[i] = ack_here && !src_all[i];
      assign clr_all_v[i]  = ack_here &&  src_all[i];
   end
endmodule

// File: rtl/ackt_tracker.sv
module ackt_tracker import ackt_pkg::*; #(
   parameter int NUM_SRC = 32,
   parameter int PRIO_W  = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        ack_req,
   output logic                        ack_vld,
   output logic [9:0]                  ack_id,
   input  logic                        cmp_req,
   input  logic [9:0]                  cmp_id,
   input  logic [9:0]                  hp_id,
   input  logic [PRIO_W-1:0]           hp_prio,
   input  logic [NUM_SRC*PRIO_W-1:0]   src_prio,
   input  logic [NUM_SRC-1:0]          src_edge,
   input  logic [NUM_SRC-1:0]          src_all,
   input  logic [NUM_SRC-1:0]          src_en,
   input  logic [NUM_SRC-1:0]          src_level,
   input  logic [NUM_SRC-1:0]          src_tgt,
   output logic [NUM_SRC-1:0]          pend_set,
   output logic [NUM_SRC-1:0]          pend_clr_self,
   output logic [NUM_SRC-1:0]          pend_clr_all,
   output logic [9:0]                  run_id,
   output logic [PRIO_W:0]             run_prio,
   output logic                        busy
);
   localparam int AW = $clog2(NUM_SRC);
   localparam int CW = $clog2(NUM_SRC + 1);
   localparam logic [ID_W-1:0] LIM_ID    = ID_W'(NUM_SRC);
   localparam logic [PRIO_W:0] IDLE_PRIO = (PRIO_W+1)'(1) << PRIO_W;
   localparam logic [CW-1:0]   STEP_MAX  = CW'(NUM_SRC - 1);

   if (NUM_SRC < 2 || NUM_SRC > 512) begin : g_bad_src
      $error("ackt_tracker: NUM_SRC must lie in 2..512");
   end
   if (PRIO_W < 1 || PRIO_W > 16) begin : g_bad_prio
      $error("ackt_tracker: PRIO_W must lie in 1..16");
   end

   ackt_state_e     state_q;
   logic [AW-1:0]   walk_cur_q;
   logic [AW-1:0]   walk_tgt_q;
   logic [CW-1:0]   walk_cnt_q;

   logic [PRIO_W-1:0] prio_arr [NUM_SRC];
   for (genvar i = 0; i < NUM_SRC; i++) begin : g_prio
      assign prio_arr[i] = src_prio[i*PRIO_W +: PRIO_W];
   end

   function automatic logic [PRIO_W:0] prio_of(input logic [ID_W-1:0] id);
      if (id < LIM_ID) return {1'b0, prio_arr[id[AW-1:0]]};
      return IDLE_PRIO;
   endfunction

   function automatic logic [ID_W-1:0] widen(input logic [AW-1:0] x);
      return {{(ID_W-AW){1'b0}}, x};
   endfunction

   logic idle, ack_go, ack_take, cmp_go, cmp_ok, cmp_pop, cmp_walk;
   assign idle     = (state_q == ACKT_IDLE);
   assign ack_go   = ack_req && idle;
   assign ack_take = ack_go && (hp_id < LIM_ID) && ({1'b0, hp_prio} < run_prio);
   assign cmp_go   = cmp_req && idle && !ack_req;
   assign cmp_ok   = cmp_go && (cmp_id < LIM_ID) && (run_id != ACKT_SPUR);
   assign cmp_pop  = cmp_ok && (cmp_id == run_id);
   assign cmp_walk = cmp_ok && !cmp_pop;

   logic [AW-1:0]   rd_a_addr, wr_addr;
   logic [ID_W-1:0] rd_a, rd_b, wr_data;
   logic            wr_en, walk_hit, walk_end;

   assign rd_a_addr = idle ? run_id[AW-1:0] : walk_cur_q;
   assign walk_hit  = !idle && (rd_a == widen(walk_tgt_q));
   assign walk_end  = !idle && (walk_hit || rd_a >= LIM_ID || walk_cnt_q == STEP_MAX);
   assign wr_en     = ack_take || walk_hit;
   assign wr_addr   = ack_take ? hp_id[AW-1:0] : walk_cur_q;
   assign wr_data   = ack_take ? run_id : rd_b;

   ackt_link_mem #(.NUM_SRC(NUM_SRC)) u_link (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (wr_en),
      .waddr   (wr_addr),
      .wdata   (wr_data),
      .raddr_a (rd_a_addr),
      .rdata_a (rd_a),
      .raddr_b (walk_tgt_q),
      .rdata_b (rd_b)
   );

   logic [NUM_SRC-1:0] set_v, clr_self_v, clr_all_v;

   ackt_pend_dec #(.NUM_SRC(NUM_SRC)) u_dec (
      .ack_fire   (ack_take),
      .ack_idx    (hp_id[AW-1:0]),
      .cmp_fire   (cmp_ok),
      .cmp_idx    (cmp_id[AW-1:0]),
      .src_edge   (src_edge),
      .src_all    (src_all),
      .src_en     (src_en),
      .src_level  (src_level),
      .src_tgt    (src_tgt),
      .set_v      (set_v),
      .clr_self_v (clr_self_v),
      .clr_all_v  (clr_all_v)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q       <= ACKT_IDLE;
         walk_cur_q    <= '0;
         walk_tgt_q    <= '0;
         walk_cnt_q    <= '0;
         run_id        <= ACKT_SPUR;
         run_prio      <= IDLE_PRIO;
         ack_vld       <= 1'b0;
         ack_id        <= ACKT_SPUR;
         pend_set      <= '0;
         pend_clr_self <= '0;
         pend_clr_all  <= '0;
      end else begin
         ack_vld       <= ack_go;
         ack_id        <= ack_take ? hp_id : ACKT_SPUR;
         pend_set      <= set_v;
         pend_clr_self <= clr_self_v;
         pend_clr_all  <= clr_all_v;
         case (state_q)
            ACKT_IDLE: begin
               if (ack_take) begin
                  run_id   <= hp_id;
                  run_prio <= {1'b0, hp_prio};
               end else if (cmp_pop) begin
                  run_id   <= rd_a;
                  run_prio <= prio_of(rd_a);
               end else if (cmp_walk) begin
                  state_q    <= ACKT_WALK;
                  walk_cur_q <= run_id[AW-1:0];
                  walk_tgt_q <= cmp_id[AW-1:0];
                  walk_cnt_q <= '0;
               end
            end
            default: begin
               if (walk_end) begin
                  state_q <= ACKT_IDLE;
               end else begin
                  walk_cur_q <= rd_a[AW-1:0];
                  walk_cnt_q <= walk_cnt_q + 1'b1;
               end
            end
         endcase
      end
   end

   assign busy = !idle;
endmodule

// File: rtl/ackt_tracker_chk.sv
module ackt_tracker_chk #(
   parameter int NUM_SRC = 32,
   parameter int PRIO_W  = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               ack_req,
   input logic               ack_vld,
   input logic [9:0]         ack_id,
   input logic               cmp_req,
   input logic [9:0]         cmp_id,
   input logic [NUM_SRC-1:0] pend_set,
   input logic [NUM_SRC-1:0] pend_clr_self,
   input logic [NUM_SRC-1:0] pend_clr_all,
   input logic [9:0]         run_id,
   input logic [PRIO_W:0]    run_prio,
   input logic               busy
);
   localparam logic [9:0]      LIM_ID    = 10'(NUM_SRC);
   localparam logic [PRIO_W:0] IDLE_PRIO = (PRIO_W+1)'(1) << PRIO_W;

   AST_SPUR_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_vld && ack_id == 10'h3FF) |-> (run_id == $past(run_id) && run_prio == $past(run_prio))); // R1
   AST_TAKEN_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_vld && ack_id != 10'h3FF) |-> (run_id == ack_id)); // R2
   AST_CLR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(pend_clr_self | pend_clr_all)); // R3
   AST_BIG_ID_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_req && !ack_req && !busy && cmp_id >= LIM_ID) |=> (run_id == $past(run_id) && !busy && pend_set == '0)); // R4
   AST_SET_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(pend_set)); // R6
   AST_IDLE_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
      (run_id == 10'h3FF) |-> (run_prio == IDLE_PRIO)); // R7
   AST_WALK_KEEPS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (run_id == $past(run_id) && run_prio == $past(run_prio))); // R8
   AST_BUSY_DROPS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !ack_vld); // R9
endmodule

bind ackt_tracker ackt_tracker_chk #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .ack_req       (ack_req),
   .ack_vld       (ack_vld),
   .ack_id        (ack_id),
   .cmp_req       (cmp_req),
   .cmp_id        (cmp_id),
   .pend_set      (pend_set),
   .pend_clr_self (pend_clr_self),
   .pend_clr_all  (pend_clr_all),
   .run_id        (run_id),
   .run_prio      (run_prio),
   .busy          (busy)
);

// File: tb/tb_ackt_tracker.sv
`timescale 1ns/1ps
module tb_ackt_tracker;
   localparam int N  = 32;
   localparam int PW = 8;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic            rst_n = 1'b0;
   logic            ack_req = 1'b0, cmp_req = 1'b0;
   logic [9:0]      cmp_id = '0, hp_id = 10'h3FF;
   logic [PW-1:0]   hp_prio = '0;
   logic [N*PW-1:0] src_prio = '1;
   logic [N-1:0]    src_edge = '1, src_all = '0, src_en = '0, src_level = '0, src_tgt = '0;
   logic            ack_vld, busy;
   logic [9:0]      ack_id, run_id;
   logic [N-1:0]    pend_set, pend_clr_self, pend_clr_all;
   logic [PW:0]     run_prio;

   ackt_tracker #(.NUM_SRC(N), .PRIO_W(PW)) dut (
      .clk(clk), .rst_n(rst_n), .ack_req(ack_req), .ack_vld(ack_vld), .ack_id(ack_id),
      .cmp_req(cmp_req), .cmp_id(cmp_id), .hp_id(hp_id), .hp_prio(hp_prio),
      .src_prio(src_prio), .src_edge(src_edge), .src_all(src_all), .src_en(src_en),
      .src_level(src_level), .src_tgt(src_tgt), .pend_set(pend_set),
      .pend_clr_self(pend_clr_self), .pend_clr_all(pend_clr_all),
      .run_id(run_id), .run_prio(run_prio), .busy(busy)
   );

   int n_cmp = 0, n_bad = 0;
   logic [9:0] expq [$];
   logic [N-1:0] got_clr_s, got_clr_a, got_set;
   bit done = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // monitor: pops expected acknowledge IDs
   always @(negedge clk) begin
      if (rst_n && ack_vld) begin
         if (expq.size() == 0) begin
            n_cmp++; n_bad++;
            $display("FAIL R9 unexpected response actual=%0h expected=none", ack_id);
         end else begin
            logic [9:0] e;
            e = expq.pop_front();
            chk("R1/R2 acknowledge id", 32'(ack_id), 32'(e));
         end
      end
   end

   task automatic set_prio(input int i, input logic [PW-1:0] p);
      src_prio[i*PW +: PW] = p;
   endtask

   task automatic do_ack(input logic [9:0] id, input logic [PW-1:0] p, input logic [9:0] exp);
      @(negedge clk);
      hp_id = id; hp_prio = p; ack_req = 1'b1;
      expq.push_back(exp);
      @(negedge clk);
      ack_req = 1'b0;
      got_clr_s = pend_clr_self; got_clr_a = pend_clr_all;
   endtask

   task automatic do_cmp(input logic [9:0] id);
      @(negedge clk);
      cmp_req = 1'b1; cmp_id = id;
      @(negedge clk);
      cmp_req = 1'b0;
      got_set = pend_set;
      while (busy) @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      set_prio(2, 8'h08); set_prio(3, 8'h30); set_prio(5, 8'h40);
      set_prio(7, 8'h20); set_prio(9, 8'h10); set_prio(1, 8'h04);
      repeat (3) @(negedge clk);
      // R10 reset state
      chk("R10 run_id", 32'(run_id), 32'h3FF);
      chk("R10 run_prio", 32'(run_prio), 32'h100);
      chk("R10 busy", 32'(busy), 0);
      chk("R10 ack_vld", 32'(ack_vld), 0);
      chk("R10 pend", 32'(pend_set | pend_clr_self | pend_clr_all), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 spurious candidate
      do_ack(10'h3FF, 8'h00, 10'h3FF);
      chk("R1 run after spurious", 32'(run_id), 32'h3FF);

      // R2 / R3 take source 5, self clear
      do_ack(10'd5, 8'h40, 10'd5);
      chk("R3 clr_self", 32'(got_clr_s), 32'h20);
      chk("R3 clr_all", 32'(got_clr_a), 0);
      chk("R2 run_id", 32'(run_id), 5);
      chk("R2 run_prio", 32'(run_prio), 32'h40);

      // R1 equal priority not taken
      do_ack(10'd3, 8'h40, 10'h3FF);
      chk("R1 equal prio keeps run", 32'(run_id), 5);
      chk("R1 no clear", 32'(got_clr_s | got_clr_a), 0);

      // R3 all-target model on source 7
      src_all[7] = 1'b1;
      do_ack(10'd7, 8'h20, 10'd7);
      chk("R3 clr_all", 32'(got_clr_a), 32'h80);
      chk("R3 clr_self none", 32'(got_clr_s), 0);
      do_ack(10'd9, 8'h10, 10'd9);
      chk("R2 nested run", 32'(run_id), 9);

      // R4 out-of-range completions
      do_cmp(10'd40);
      chk("R4 id 40 run", 32'(run_id), 9);
      chk("R4 id 40 set", 32'(got_set), 0);
      do_cmp(10'h3FF);
      chk("R4 id 1023 run", 32'(run_id), 9);

      // R8 / R6 out-of-order completion of 7, level source still asserted
      src_edge[7] = 1'b0; src_en[7] = 1'b1; src_level[7] = 1'b1; src_tgt[7] = 1'b1;
      do_cmp(10'd7);
      chk("R6 repend 7", 32'(got_set), 32'h80);
      chk("R8 run kept", 32'(run_id), 9);
      chk("R8 prio kept", 32'(run_prio), 32'h10);

      // R7 pops: 9 -> 5 (7 unlinked) -> idle
      do_cmp(10'd9);
      chk("R7/R8 pop to 5", 32'(run_id), 5);
      chk("R7 prio of 5", 32'(run_prio), 32'h40);
      do_cmp(10'd5);
      chk("R7 pop to idle", 32'(run_id), 32'h3FF);
      chk("R7 idle prio", 32'(run_prio), 32'h100);

      // R5 completion with nothing running
      src_edge[5] = 1'b0; src_en[5] = 1'b1; src_level[5] = 1'b1; src_tgt[5] = 1'b1;
      do_cmp(10'd5);
      chk("R5 no repend", 32'(got_set), 0);
      chk("R5 run idle", 32'(run_id), 32'h3FF);

      // R6 edge source is not re-pended
      src_edge[7] = 1'b1;
      do_ack(10'd7, 8'h20, 10'd7);
      do_cmp(10'd7);
      chk("R6 edge no repend", 32'(got_set), 0);
      chk("R6 run idle", 32'(run_id), 32'h3FF);

      // R9 acknowledge beats a same-cycle completion
      do_ack(10'd9, 8'h10, 10'd9);
      @(negedge clk);
      hp_id = 10'd2; hp_prio = 8'h08; ack_req = 1'b1; cmp_req = 1'b1; cmp_id = 10'd9;
      expq.push_back(10'd2);
      @(negedge clk);
      ack_req = 1'b0; cmp_req = 1'b0;
      chk("R9 ack wins run", 32'(run_id), 2);
      chk("R9 completion dropped", 32'(busy), 0);

      // R9 acknowledge during a walk is dropped; R8 splice to idle
      @(negedge clk);
      cmp_req = 1'b1; cmp_id = 10'd9;
      @(negedge clk);
      cmp_req = 1'b0;
      chk("R8 busy raised", 32'(busy), 1);
      hp_id = 10'd1; hp_prio = 8'h04; ack_req = 1'b1;
      @(negedge clk);
      ack_req = 1'b0;
      chk("R9 no response while busy", 32'(ack_vld), 0);
      chk("R9 run unchanged", 32'(run_id), 2);
      while (busy) @(negedge clk);
      do_cmp(10'd2);
      chk("R8 spliced chain to idle", 32'(run_id), 32'h3FF);
      chk("R8 idle prio", 32'(run_prio), 32'h100);

      repeat (3) @(negedge clk);
      chk("R2 all responses seen", 32'(expq.size()), 0);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule